// File: doc/BRIEF.md
# Paged Program Counter Unit

This block owns the instruction address of a small processor core. It holds a program counter made of a low byte and a high byte. It also holds a separate page field, which is the top bits of the status register, and a shadow copy of that field. On each clock edge the unit takes at most one event. Sequential advance adds one to the counter. A software write to the low byte is a computed jump. If the write came from an addition that carried, the high byte is bumped by one. That high byte is never written directly.

The page field does not follow the counter. It enters address generation only when a jump or call is taken. The target is then the page field followed by the operand of the instruction. Software can set the field through a status write. Taking an interrupt loads the counter with the vector and loads the page field with the top bits of that vector. The field value from before the interrupt goes into the shadow. A return from interrupt puts the shadow back into the page field, and the counter takes the return address that the external stack supplies.

Top module: `ppc_unit`

## Requirements
- R1: While reset is asserted, and after it is released, the counter, page field and shadow are all zero.
- R2: With only the advance strobe high, the counter goes up by one at the next edge. 0xFFFF wraps to 0x0000. Page field and shadow are unchanged.
- R3: A low-byte write with the carry flag clear sets counter bits 7:0 to the written data. Bits 15:8 and the page field are unchanged.
- R4: A low-byte write with the carry flag set also adds one to counter bits 15:8. 0xFF wraps to 0x00.
- R5: A jump or call loads the counter with {page field, 13-bit operand}, with the page field in bits 15:13. The page field is unchanged.
- R6: A status page write sets the page field to the given 3-bit value. The counter and shadow hold.
- R7: Taking an interrupt loads the counter with the 16-bit vector and the page field with vector bits 15:13. The shadow captures the page field value from before that edge.
- R8: A return from interrupt loads the page field from the shadow and the counter from the return address. The shadow holds.
- R9: When several strobes are high together, one event is taken, in this order: interrupt, return, jump, low-byte write, page write, advance.
- R10: With no strobe high, the counter, page field and shadow hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Sequential advance |
| lo_wr_i | input | 1 | Low-byte write strobe (computed jump) |
| lo_data_i | input | 8 | Data for the low byte |
| lo_carry_i | input | 1 | Carry out of the add that produced lo_data_i |
| jump_i | input | 1 | Jump or call taken |
| jump_opnd_i | input | 13 | Jump or call operand |
| page_wr_i | input | 1 | Status page field write |
| page_data_i | input | 3 | New page field value |
| irq_i | input | 1 | Interrupt taken |
| irq_vec_i | input | 16 | Interrupt vector address |
| reti_i | input | 1 | Return from interrupt |
| ret_addr_i | input | 16 | Return address from the stack |
| pc_o | output | 16 | Program counter |
| page_o | output | 3 | Page field |
| shadow_o | output | 3 | Shadow page field |

## Verification
The bench builds the unit with its default widths: a 16-bit counter, an 8-bit low byte and a 3-bit page field. At these sizes, one interrupt vector can put the counter at 0xFFFF or the high byte at 0xFF in a single cycle. That makes the full-counter wrap and the high-byte wrap on carry easy to reach. The random strobes often overlap, so the six-way priority order is exercised. The 3-bit page field is small, so shadow save and restore cover every value many times.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    typedef enum logic [2:0] {
        EV_IDLE   = 3'd0,
        EV_STEP   = 3'd1,
        EV_PAGEWR = 3'd2,
        EV_LOWR   = 3'd3,
        EV_JUMP   = 3'd4,
        EV_RETI   = 3'd5,
        EV_IRQ    = 3'd6
    } ppc_ev_e;

endpackage

// File: rtl/ppc_arbiter.sv
module ppc_arbiter
    import ppc_pkg::*;
(
    input  logic    irq_i,
    input  logic    reti_i,
    input  logic    jump_i,
    input  logic    lo_wr_i,
    input  logic    page_wr_i,
    input  logic    step_i,
    output ppc_ev_e ev_o
);

    // Fixed priority, highest first.
    always_comb begin
        if (irq_i)          ev_o = EV_IRQ;
        else if (reti_i)    ev_o = EV_RETI;
        else if (jump_i)    ev_o = EV_JUMP;
        else if (lo_wr_i)   ev_o = EV_LOWR;
        else if (page_wr_i) ev_o = EV_PAGEWR;
        else if (step_i)    ev_o = EV_STEP;
        else                ev_o = EV_IDLE;
    end

endmodule

// File: rtl/ppc_target.sv
module ppc_target #(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 3,
    parameter int LO_W   = 8,
    localparam int HI_W  = PC_W - LO_W,
    localparam int OP_W  = PC_W - PAGE_W
) (
    input  logic [PC_W-1:0]   pc_q_i,
    input  logic [PAGE_W-1:0] page_q_i,
    input  logic [LO_W-1:0]   lo_data_i,
    input  logic              lo_carry_i,
    input  logic [OP_W-1:0]   jump_opnd_i,
    output logic [PC_W-1:0]   step_pc_o,
    output logic [PC_W-1:0]   lowr_pc_o,
    output logic [PC_W-1:0]   jump_pc_o
);

    logic [HI_W-1:0] hi_cur;
    logic [HI_W-1:0] hi_inc;

    always_comb begin
        step_pc_o = pc_q_i + {{(PC_W-1){1'b0}}, 1'b1};
        hi_cur    = pc_q_i[PC_W-1:LO_W];
        hi_inc    = hi_cur + {{(HI_W-1){1'b0}}, lo_carry_i};
        lowr_pc_o = {hi_inc, lo_data_i};
        jump_pc_o = {page_q_i, jump_opnd_i};
    end

endmodule

// File: rtl/ppc_page.sv
module ppc_page
    import ppc_pkg::*;
#(
    parameter int PAGE_W = 3
) (
    input  ppc_ev_e           ev_i,
    input  logic [PAGE_W-1:0] page_q_i,
    input  logic [PAGE_W-1:0] shadow_q_i,
    input  logic [PAGE_W-1:0] page_data_i,
    input  logic [PAGE_W-1:0] vec_page_i,
    output logic [PAGE_W-1:0] page_d_o,
    output logic [PAGE_W-1:0] shadow_d_o
);

    always_comb begin
        page_d_o   = page_q_i;
        shadow_d_o = shadow_q_i;
        unique case (ev_i)
            EV_IRQ: begin
                page_d_o   = vec_page_i;
                shadow_d_o = page_q_i;
            end
            EV_RETI:   page_d_o = shadow_q_i;
            EV_PAGEWR: page_d_o = page_data_i;
            default: ;
        endcase
    end

endmodule

// File: rtl/ppc_unit.sv
module ppc_unit
    import ppc_pkg::*;
#(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 3,
    parameter int LO_W   = 8,
    localparam int OP_W  = PC_W - PAGE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              lo_wr_i,
    input  logic [LO_W-1:0]   lo_data_i,
    input  logic              lo_carry_i,
    input  logic              jump_i,
    input  logic [OP_W-1:0]   jump_opnd_i,
    input  logic              page_wr_i,
    input  logic [PAGE_W-1:0] page_data_i,
    input  logic              irq_i,
    input  logic [PC_W-1:0]   irq_vec_i,
    input  logic              reti_i,
    input  logic [PC_W-1:0]   ret_addr_i,
    output logic [PC_W-1:0]   pc_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [PAGE_W-1:0] shadow_o
);

    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [PAGE_W-1:0] page;
        logic [PAGE_W-1:0] shadow;
    } state_t;

    state_t  st_d, st_q;
    ppc_ev_e ev;

    logic [PC_W-1:0]   step_pc, lowr_pc, jump_pc;
    logic [PAGE_W-1:0] page_nx, shadow_nx;

    ppc_arbiter u_arb (
        .irq_i     (irq_i),
        .reti_i    (reti_i),
        .jump_i    (jump_i),
        .lo_wr_i   (lo_wr_i),
        .page_wr_i (page_wr_i),
        .step_i    (step_i),
        .ev_o      (ev)
    );

    ppc_target #(
        .PC_W   (PC_W),
        .PAGE_W (PAGE_W),
        .LO_W   (LO_W)
    ) u_tgt (
        .pc_q_i      (st_q.pc),
        .page_q_i    (st_q.page),
        .lo_data_i   (lo_data_i),
        .lo_carry_i  (lo_carry_i),
        .jump_opnd_i (jump_opnd_i),
        .step_pc_o   (step_pc),
        .lowr_pc_o   (lowr_pc),
        .jump_pc_o   (jump_pc)
    );

    ppc_page #(
        .PAGE_W (PAGE_W)
    ) u_page (
        .ev_i        (ev),
        .page_q_i    (st_q.page),
        .shadow_q_i  (st_q.shadow),
        .page_data_i (page_data_i),
        .vec_page_i  (irq_vec_i[PC_W-1 -: PAGE_W]),
        .page_d_o    (page_nx),
        .shadow_d_o  (shadow_nx)
    );

    always_comb begin
        st_d        = st_q;
        st_d.page   = page_nx;
        st_d.shadow = shadow_nx;
        unique case (ev)
            EV_IRQ:  st_d.pc = irq_vec_i;
            EV_RETI: st_d.pc = ret_addr_i;
            EV_JUMP: st_d.pc = jump_pc;
            EV_LOWR: st_d.pc = lowr_pc;
            EV_STEP: st_d.pc = step_pc;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o     = st_q.pc;
    assign page_o   = st_q.page;
    assign shadow_o = st_q.shadow;

endmodule

// File: rtl/ppc_unit_chk.sv
module ppc_unit_chk #(
    parameter int PC_W   = 16,
    parameter int PAGE_W = 3,
    parameter int LO_W   = 8,
    localparam int OP_W  = PC_W - PAGE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_i,
    input logic              lo_wr_i,
    input logic [LO_W-1:0]   lo_data_i,
    input logic              lo_carry_i,
    input logic              jump_i,
    input logic [OP_W-1:0]   jump_opnd_i,
    input logic              page_wr_i,
    input logic [PAGE_W-1:0] page_data_i,
    input logic              irq_i,
    input logic [PC_W-1:0]   irq_vec_i,
    input logic              reti_i,
    input logic [PC_W-1:0]   ret_addr_i,
    input logic [PC_W-1:0]   pc_o,
    input logic [PAGE_W-1:0] page_o,
    input logic [PAGE_W-1:0] shadow_o
);

    logic above_lowr;
    logic any_ev;
    assign above_lowr = irq_i || reti_i || jump_i;
    assign any_ev     = above_lowr || lo_wr_i || page_wr_i || step_i;

    // R2
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !any_ev_but_step()) |=>
            (pc_o == $past(pc_o) + 1'b1) && $stable(page_o) && $stable(shadow_o));

    // R3
    lowr_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_i && !above_lowr && !lo_carry_i) |=>
            (pc_o[PC_W-1:LO_W] == $past(pc_o[PC_W-1:LO_W])) &&
            (pc_o[LO_W-1:0] == $past(lo_data_i)) && $stable(page_o));

    // R5
    jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_i && !irq_i && !reti_i) |=>
            (pc_o == {$past(page_o), $past(jump_opnd_i)}) && $stable(page_o));

    // R7
    irq_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> (shadow_o == $past(page_o)) &&
                  (page_o == $past(irq_vec_i[PC_W-1 -: PAGE_W])) &&
                  (pc_o == $past(irq_vec_i)));

    // R8
    reti_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_i && !irq_i) |=> (page_o == $past(shadow_o)) && $stable(shadow_o) &&
                               (pc_o == $past(ret_addr_i)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ev |=> $stable(pc_o) && $stable(page_o) && $stable(shadow_o));

    function automatic logic any_ev_but_step();
        return above_lowr || lo_wr_i || page_wr_i;
    endfunction

    logic unused_ok;
    assign unused_ok = ^{page_data_i, lo_carry_i};

endmodule

bind ppc_unit ppc_unit_chk #(
    .PC_W   (PC_W),
    .PAGE_W (PAGE_W),
    .LO_W   (LO_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_i      (step_i),
    .lo_wr_i     (lo_wr_i),
    .lo_data_i   (lo_data_i),
    .lo_carry_i  (lo_carry_i),
    .jump_i      (jump_i),
    .jump_opnd_i (jump_opnd_i),
    .page_wr_i   (page_wr_i),
    .page_data_i (page_data_i),
    .irq_i       (irq_i),
    .irq_vec_i   (irq_vec_i),
    .reti_i      (reti_i),
    .ret_addr_i  (ret_addr_i),
    .pc_o        (pc_o),
    .page_o      (page_o),
    .shadow_o    (shadow_o)
);

// File: tb/ppc_unit_bench.sv
module ppc_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, lo_wr_i = 1'b0, lo_carry_i = 1'b0, jump_i = 1'b0;
    logic        page_wr_i = 1'b0, irq_i = 1'b0, reti_i = 1'b0;
    logic [7:0]  lo_data_i = '0;
    logic [12:0] jump_opnd_i = '0;
    logic [2:0]  page_data_i = '0;
    logic [15:0] irq_vec_i = '0, ret_addr_i = '0;
    logic [15:0] pc_o;
    logic [2:0]  page_o, shadow_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] m_pc = '0;
    logic [2:0]  m_page = '0, m_shadow = '0;
    bit done = 0;

    always #4 clk = ~clk;

    ppc_unit u_ppc_unit (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .lo_wr_i(lo_wr_i),
        .lo_data_i(lo_data_i), .lo_carry_i(lo_carry_i), .jump_i(jump_i),
        .jump_opnd_i(jump_opnd_i), .page_wr_i(page_wr_i), .page_data_i(page_data_i),
        .irq_i(irq_i), .irq_vec_i(irq_vec_i), .reti_i(reti_i), .ret_addr_i(ret_addr_i),
        .pc_o(pc_o), .page_o(page_o), .shadow_o(shadow_o)
    );

    task automatic check(input string req);
        n_chk++;
        if (pc_o !== m_pc || page_o !== m_page || shadow_o !== m_shadow) begin
            n_bad++;
            $display("FAIL %s: pc/page/shadow got %h/%0d/%0d expected %h/%0d/%0d",
                     req, pc_o, page_o, shadow_o, m_pc, m_page, m_shadow);
        end
    endtask

    // Reference model of one edge; returns the requirement tag of the event.
    function automatic string model_step();
        int strobes;
        strobes = irq_i + reti_i + jump_i + lo_wr_i + page_wr_i + step_i;
        if (irq_i) begin
            m_shadow = m_page; m_page = irq_vec_i[15:13]; m_pc = irq_vec_i;
            return (strobes > 1) ? "R9 (irq wins), R7" : "R7 irq";
        end
        if (reti_i) begin
            m_page = m_shadow; m_pc = ret_addr_i;
            return (strobes > 1) ? "R9 (reti wins), R8" : "R8 reti";
        end
        if (jump_i) begin
            m_pc = {m_page, jump_opnd_i};
            return (strobes > 1) ? "R9 (jump wins), R5" : "R5 jump";
        end
        if (lo_wr_i) begin
            m_pc = {m_pc[15:8] + {7'd0, lo_carry_i}, lo_data_i};
            return lo_carry_i ? "R4 low write carry" : "R3 low write";
        end
        if (page_wr_i) begin
            m_page = page_data_i;
            return "R6 page write";
        end
        if (step_i) begin
            m_pc = m_pc + 16'd1;
            return "R2 step";
        end
        return "R10 idle";
    endfunction

    task automatic clear_in();
        step_i = 0; lo_wr_i = 0; lo_carry_i = 0; jump_i = 0;
        page_wr_i = 0; irq_i = 0; reti_i = 0;
    endtask

    // Inputs are set after a falling edge; result sampled 1 ns after the rising edge.
    task automatic run_cycle();
        string tag;
        @(posedge clk);
        tag = model_step();
        #1;
        check(tag);
        @(negedge clk);
        clear_in();
    endtask

    task automatic do_irq(input logic [15:0] v);
        irq_i = 1; irq_vec_i = v; run_cycle();
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release");

        // R2: full wrap 0xFFFF -> 0x0000
        do_irq(16'hFFFF);
        step_i = 1; run_cycle();
        // R4: high byte wrap 0xFF -> 0x00 on carry
        do_irq(16'hFF10);
        lo_wr_i = 1; lo_carry_i = 1; lo_data_i = 8'h05; run_cycle();
        // R3: no carry keeps high byte
        do_irq(16'h4A10);
        lo_wr_i = 1; lo_carry_i = 0; lo_data_i = 8'hC3; run_cycle();
        // R6 then R5: page write used by jump
        page_wr_i = 1; page_data_i = 3'd6; run_cycle();
        jump_i = 1; jump_opnd_i = 13'h1ABC; run_cycle();
        // R7/R8: nested save and restore
        do_irq(16'h2000);
        reti_i = 1; ret_addr_i = 16'h1234; run_cycle();
        // R9: all strobes together, irq wins
        irq_i = 1; irq_vec_i = 16'hE001; reti_i = 1; jump_i = 1; lo_wr_i = 1;
        page_wr_i = 1; step_i = 1; run_cycle();
        // R9: jump over low write
        jump_i = 1; jump_opnd_i = 13'h0077; lo_wr_i = 1; lo_data_i = 8'h11; run_cycle();
        // R10: idle
        run_cycle();

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            irq_i       = ($urandom_range(0, 15) == 0);
            reti_i      = ($urandom_range(0, 11) == 0);
            jump_i      = ($urandom_range(0, 7) == 0);
            lo_wr_i     = ($urandom_range(0, 5) == 0);
            page_wr_i   = ($urandom_range(0, 7) == 0);
            step_i      = ($urandom_range(0, 2) != 0);
            lo_carry_i  = $urandom_range(0, 1);
            lo_data_i   = 8'($urandom);
            jump_opnd_i = 13'($urandom);
            page_data_i = 3'($urandom);
            irq_vec_i   = 16'($urandom);
            ret_addr_i  = 16'($urandom);
            run_cycle();
        end

        // R1: reset in mid-run returns to zero
        rst_n = 1'b0;
        @(posedge clk); #1;
        m_pc = '0; m_page = '0; m_shadow = '0;
        check("R1 re-reset");
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: run did not finish, got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule